// File: doc/BRIEF.md
# Display Controller Indexed Register Port

This block is the host-side register front end of a display controller. The host sees a handful of 32-bit ports at small offsets. To reach any register it first writes that register's number to the index port and then reads or writes the value port. The block holds the mode state: an enable flag, a configuration-complete flag, the width and the height. It also holds the hardware cursor state (identifier, X, Y and a visible flag), a device version register that is settled by negotiation with the host, and a small bank of scratch words. A set of read-only registers reports the fixed colour depth, the size limits, the line pitch and a capability mask. Writing a nonzero value to the sync register sends a single-cycle start pulse to the command processor.

Access rules:
- Requests are accepted in every cycle. The port has no back-pressure: `wr_en` and `rd_en` are single-cycle strobes with nothing to stall them.
- Every read returns exactly one `rd_valid` beat in the cycle after the request.
- The port stride is picked by a parameter: 1 in version-2 mode, 4 in version-1 mode. The index port sits at 0 × stride, the value port at 1 × stride and the firmware port at 2 × stride.

Top module: `disp_regport`

## Requirements
- R1: After reset, `enable`, `config_done` and `cursor_visible` are 0 and the index register reads 0. The version register (value-port index 0) reads 0x90000002.
- R2: With the default stride of 1:
  - a read at offset 0 returns the index register and a write there loads it;
  - offset 1 is the value port;
  - offset 2 reads 0 and ignores writes;
  - any other offset reads 0xFFFFFFFF and ignores writes.
- R3: An access whose `acc_bytes` is not 4 is illegal. An illegal write changes nothing, and an illegal read returns 0xFFFFFFFF.
- R4: A write to index 0 is taken only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R5: Index 2 (width) accepts a value no greater than MAX_W (default 2368). Index 3 (height) accepts a value no greater than MAX_H (default 1770). A rejected value leaves the register unchanged. The outputs `width` and `height` follow these registers.
- R6: Index 6 (depth) reads 24 when DEPTH is 32 and reads DEPTH otherwise. Index 7 (bits per pixel) reads DEPTH.
- R7: Index 12 reads DEPTH × width / 8.
- R8: Indices SCR_BASE (1792) to SCR_BASE+SCR_N−1 are read/write scratch words.
  - A value-port access to an index that maps to no register pulses `bad_reg` for one cycle, in the cycle after the access.
  - Such a read returns 0.
  - Indices just outside the scratch window count as unmapped.
- R9: A write of 1 to index 27 sets `cursor_visible`, a write of 0 clears it, and any other value leaves it unchanged. Indices 24, 25 and 26 hold the cursor identifier, X and Y; each reads back and drives its output.
- R10: Index 17 reads 0x000000E3 when CURSOR_CAP is 1. In that word, bit 0 is fill, bit 1 is copy, and bits 5, 6 and 7 are cursor support. Index 4 reads MAX_W and index 5 reads MAX_H.
- R11: A nonzero write to index 21 raises `sync_start` for exactly the one cycle after the write. A write of zero raises nothing.
- R12: A legal or illegal read request gives `rd_valid` with its data in the following cycle, and `rd_valid` never rises without a request.
- R13: Indices 1 (enable) and 20 (config done) store 1 for any nonzero value and 0 for zero. Each reads back and drives its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Port offset |
| acc_bytes | input | 3 | Access size in bytes; only 4 is legal |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| bad_reg | output | 1 | Pulse for an access to an unmapped index |
| enable | output | 1 | Controller enable |
| config_done | output | 1 | Configuration complete |
| width | output | $clog2(MAX_W+1) | Current width |
| height | output | $clog2(MAX_H+1) | Current height |
| cursor_id | output | 32 | Cursor identifier |
| cursor_x | output | 32 | Cursor X |
| cursor_y | output | 32 | Cursor Y |
| cursor_visible | output | 1 | Cursor shown |
| sync_start | output | 1 | One-cycle command processor start |

## Verification
Version writes are tried with each of the three legal codes and with two illegal ones, so the bench can tell an exact-match filter from a mask on the upper bits. Width and height are driven at the limit and at one above it, and the pitch is read for several widths, which separates a bound check that is off by one from a correct one. Cursor-visible writes run through the values 1, 2, 0, 3 and 1, so a design that treats every nonzero value as "show" gives a different result. Scratch indices are probed at both ends of the window and one step past each end, and port offsets and access sizes outside the legal set are probed for the all-ones read.

// File: rtl/disp_regport_pkg.sv
package disp_regport_pkg;

  localparam logic [31:0] VER_MAGIC = 32'h9000_0000;

  // value-port register numbers decoded by host drivers
  localparam int IX_VERSION  = 0;
  localparam int IX_ENABLE   = 1;
  localparam int IX_WIDTH    = 2;
  localparam int IX_HEIGHT   = 3;
  localparam int IX_MAXW     = 4;
  localparam int IX_MAXH     = 5;
  localparam int IX_DEPTH    = 6;
  localparam int IX_BPP      = 7;
  localparam int IX_PITCH    = 12;
  localparam int IX_CAPS     = 17;
  localparam int IX_CFGDONE  = 20;
  localparam int IX_SYNC     = 21;
  localparam int IX_BUSY     = 22;
  localparam int IX_CUR_ID   = 24;
  localparam int IX_CUR_X    = 25;
  localparam int IX_CUR_Y    = 26;
  localparam int IX_CUR_SHOW = 27;

  function automatic logic [31:0] ver_code(input logic [1:0] v);
    return VER_MAGIC | {30'd0, v};
  endfunction

  typedef struct packed {
    logic idx_wr;
    logic idx_rd;
    logic val_wr;
    logic val_rd;
    logic fw_rd;
    logic ones_rd;
  } port_dec_t;

endpackage

// File: rtl/disp_regport_decode.sv
module disp_regport_decode
  import disp_regport_pkg::*;
#(
  parameter int AW     = 4,
  parameter int STRIDE = 1
) (
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    acc_bytes,
  output port_dec_t     dec
);
  localparam logic [AW-1:0] OFF_IDX = AW'(0);
  localparam logic [AW-1:0] OFF_VAL = AW'(STRIDE);
  localparam logic [AW-1:0] OFF_FW  = AW'(2 * STRIDE);

  logic legal, hit_idx, hit_val, hit_fw;

  always_comb begin
    legal   = (acc_bytes == 3'd4);
    hit_idx = (addr == OFF_IDX);
    hit_val = (addr == OFF_VAL);
    hit_fw  = (addr == OFF_FW);
    dec.idx_wr  = wr_en & legal & hit_idx;
    dec.val_wr  = wr_en & legal & hit_val;
    dec.idx_rd  = rd_en & legal & hit_idx;
    dec.val_rd  = rd_en & legal & hit_val;
    dec.fw_rd   = rd_en & legal & hit_fw;
    dec.ones_rd = rd_en & (~legal | ~(hit_idx | hit_val | hit_fw));
  end
endmodule

// File: rtl/disp_regport_ctrl.sv
module disp_regport_ctrl
  import disp_regport_pkg::*;
#(
  parameter int MAX_W      = 2368,
  parameter int MAX_H      = 1770,
  parameter int DEPTH      = 32,
  parameter bit CURSOR_CAP = 1'b1,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          val_wr,
  input  logic [31:0]   idx,
  input  logic [31:0]   wdata,
  output logic          enable,
  output logic          config_done,
  output logic [WW-1:0] width,
  output logic [HW-1:0] height,
  output logic [31:0]   cursor_id,
  output logic [31:0]   cursor_x,
  output logic [31:0]   cursor_y,
  output logic          cursor_visible,
  output logic          sync_start,
  output logic [31:0]   rdata,
  output logic          rd_hit,
  output logic          wr_hit
);
  localparam logic [31:0] DEPTH_W  = 32'(DEPTH);
  localparam logic [31:0] DEPTH_RD = (DEPTH == 32) ? 32'd24 : DEPTH_W;
  localparam logic [31:0] CAPS     = 32'h3 | (CURSOR_CAP ? 32'hE0 : 32'h0);

  logic [31:0] version_q;
  logic [31:0] pitch;
  logic        ver_ok;

  always_comb begin
    ver_ok = (wdata == ver_code(2'd0)) || (wdata == ver_code(2'd1)) ||
             (wdata == ver_code(2'd2));
    pitch  = (DEPTH_W * 32'(width)) >> 3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      version_q      <= ver_code(2'd2);
      enable         <= 1'b0;
      config_done    <= 1'b0;
      width          <= '0;
      height         <= '0;
      cursor_id      <= '0;
      cursor_x       <= '0;
      cursor_y       <= '0;
      cursor_visible <= 1'b0;
      sync_start     <= 1'b0;
    end else begin
      sync_start <= 1'b0;
      if (val_wr) begin
        case (idx)
          IX_VERSION:  if (ver_ok) version_q <= wdata;
          IX_ENABLE:   enable <= |wdata;
          IX_WIDTH:    if (wdata <= 32'(MAX_W)) width <= wdata[WW-1:0];
          IX_HEIGHT:   if (wdata <= 32'(MAX_H)) height <= wdata[HW-1:0];
          IX_CFGDONE:  config_done <= |wdata;
          IX_SYNC:     sync_start <= |wdata;
          IX_CUR_ID:   cursor_id <= wdata;
          IX_CUR_X:    cursor_x <= wdata;
          IX_CUR_Y:    cursor_y <= wdata;
          IX_CUR_SHOW: begin
            if (wdata == 32'd1)      cursor_visible <= 1'b1;
            else if (wdata == 32'd0) cursor_visible <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rdata  = '0;
    case (idx)
      IX_VERSION:  rdata = version_q;
      IX_ENABLE:   rdata = {31'd0, enable};
      IX_WIDTH:    rdata = 32'(width);
      IX_HEIGHT:   rdata = 32'(height);
      IX_MAXW:     rdata = 32'(MAX_W);
      IX_MAXH:     rdata = 32'(MAX_H);
      IX_DEPTH:    rdata = DEPTH_RD;
      IX_BPP:      rdata = DEPTH_W;
      IX_PITCH:    rdata = pitch;
      IX_CAPS:     rdata = CAPS;
      IX_CFGDONE:  rdata = {31'd0, config_done};
      IX_SYNC:     rdata = '0;
      IX_BUSY:     rdata = '0;
      IX_CUR_ID:   rdata = cursor_id;
      IX_CUR_X:    rdata = cursor_x;
      IX_CUR_Y:    rdata = cursor_y;
      IX_CUR_SHOW: rdata = {31'd0, cursor_visible};
      default:     rd_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (idx)
      IX_VERSION, IX_ENABLE, IX_WIDTH, IX_HEIGHT, IX_DEPTH, IX_BPP,
      IX_CFGDONE, IX_SYNC, IX_CUR_ID, IX_CUR_X, IX_CUR_Y, IX_CUR_SHOW:
        wr_hit = 1'b1;
      default: wr_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/disp_regport_scratch.sv
module disp_regport_scratch #(
  parameter int SCR_BASE = 1792,
  parameter int SCR_N    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        val_wr,
  input  logic [31:0] idx,
  input  logic [31:0] wdata,
  output logic        hit,
  output logic [31:0] rdata
);
  localparam logic [31:0] LO = 32'(SCR_BASE);
  localparam logic [31:0] HI = 32'(SCR_BASE + SCR_N);

  logic [31:0] words [SCR_N];
  logic [31:0] off;

  always_comb begin
    hit   = (idx >= LO) && (idx < HI);
    off   = idx - LO;
    rdata = '0;
    for (int k = 0; k < SCR_N; k++) begin
      if (hit && off == 32'(k)) rdata = words[k];
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                  words[g] <= '0;
      else if (val_wr && hit && off == 32'(g))     words[g] <= wdata;
    end
  end
endmodule

// File: rtl/disp_regport.sv
module disp_regport
  import disp_regport_pkg::*;
#(
  parameter bit VERSION2   = 1'b1,
  parameter int AW         = 4,
  parameter int MAX_W      = 2368,
  parameter int MAX_H      = 1770,
  parameter int DEPTH      = 32,
  parameter bit CURSOR_CAP = 1'b1,
  parameter int SCR_BASE   = 1792,
  parameter int SCR_N      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [AW-1:0]                addr,
  input  logic [2:0]                   acc_bytes,
  input  logic [31:0]                  wdata,
  output logic                         rd_valid,
  output logic [31:0]                  rd_data,
  output logic                         bad_reg,
  output logic                         enable,
  output logic                         config_done,
  output logic [$clog2(MAX_W+1)-1:0]   width,
  output logic [$clog2(MAX_H+1)-1:0]   height,
  output logic [31:0]                  cursor_id,
  output logic [31:0]                  cursor_x,
  output logic [31:0]                  cursor_y,
  output logic                         cursor_visible,
  output logic                         sync_start
);
  localparam int STRIDE = VERSION2 ? 1 : 4;

  port_dec_t   dec;
  logic [31:0] index_q;
  logic [31:0] ctrl_rdata, scr_rdata, rd_next;
  logic        ctrl_rhit, ctrl_whit, scr_hit, bad_next;

  disp_regport_decode #(.AW(AW), .STRIDE(STRIDE)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .acc_bytes(acc_bytes), .dec(dec)
  );

  disp_regport_ctrl #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .DEPTH(DEPTH), .CURSOR_CAP(CURSOR_CAP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .val_wr(dec.val_wr), .idx(index_q), .wdata(wdata),
    .enable(enable), .config_done(config_done), .width(width), .height(height),
    .cursor_id(cursor_id), .cursor_x(cursor_x), .cursor_y(cursor_y),
    .cursor_visible(cursor_visible), .sync_start(sync_start),
    .rdata(ctrl_rdata), .rd_hit(ctrl_rhit), .wr_hit(ctrl_whit)
  );

  disp_regport_scratch #(.SCR_BASE(SCR_BASE), .SCR_N(SCR_N)) u_scr (
    .clk(clk), .rst_n(rst_n), .val_wr(dec.val_wr), .idx(index_q), .wdata(wdata),
    .hit(scr_hit), .rdata(scr_rdata)
  );

  always_comb begin
    rd_next = '0;
    if (dec.ones_rd)     rd_next = '1;
    else if (dec.idx_rd) rd_next = index_q;
    else if (dec.val_rd) rd_next = ctrl_rhit ? ctrl_rdata : scr_rdata;
    bad_next = (dec.val_rd & ~ctrl_rhit & ~scr_hit) |
               (dec.val_wr & ~ctrl_whit & ~scr_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bad_reg  <= 1'b0;
    end else begin
      if (dec.idx_wr) index_q <= wdata;
      rd_valid <= rd_en;
      rd_data  <= rd_next;
      bad_reg  <= bad_next;
    end
  end
endmodule

// File: rtl/disp_regport_chk.sv
module disp_regport_chk #(
  parameter int MAX_W = 2368,
  parameter int MAX_H = 1770,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          bad_reg,
  input logic          sync_start,
  input logic          enable,
  input logic [WW-1:0] width,
  input logic [HW-1:0] height
);
  AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);  // R12
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));  // R12
  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(width) <= 32'(MAX_W));  // R5
  AST_HEIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(height) <= 32'(MAX_H));  // R5
  AST_SYNC_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |-> $past(wr_en));  // R11
  AST_BAD_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_reg |-> $past(wr_en || rd_en));  // R8
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(enable));  // R13
endmodule

bind disp_regport disp_regport_chk #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid),
  .bad_reg(bad_reg), .sync_start(sync_start), .enable(enable),
  .width(width), .height(height)
);

// File: tb/test_disp_regport.sv
module test_disp_regport;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_W = 2368;
  localparam int MAX_H = 1770;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [2:0]  acc_bytes = 3'd4;
  logic [31:0] wdata = '0;
  logic        rd_valid, bad_reg, enable, config_done, cursor_visible, sync_start;
  logic [31:0] rd_data, cursor_id, cursor_x, cursor_y;
  logic [11:0] width;
  logic [10:0] height;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_regport i_disp_regport (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_bytes(acc_bytes), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .bad_reg(bad_reg), .enable(enable), .config_done(config_done),
    .width(width), .height(height), .cursor_id(cursor_id), .cursor_x(cursor_x),
    .cursor_y(cursor_y), .cursor_visible(cursor_visible), .sync_start(sync_start)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read beat
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R12 unexpected rd_valid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic put(int off, logic [31:0] d, int nb = 4);
    @(negedge clk);
    addr = 4'(off); wdata = d; acc_bytes = 3'(nb); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; acc_bytes = 3'd4;
  endtask

  task automatic get(int off, logic [31:0] exp, string tag, int nb = 4);
    @(negedge clk);
    addr = 4'(off); acc_bytes = 3'(nb); rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; acc_bytes = 3'd4;
  endtask

  task automatic setreg(int idx, logic [31:0] v);
    put(0, 32'(idx)); put(1, v);
  endtask

  task automatic rdreg(int idx, logic [31:0] exp, string tag);
    put(0, 32'(idx)); get(1, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 enable", {31'd0, enable}, 0);
    chk("R1 config_done", {31'd0, config_done}, 0);
    chk("R1 cursor_visible", {31'd0, cursor_visible}, 0);
    get(0, 32'd0, "R1 index reset");
    rdreg(0, 32'h9000_0002, "R1 version reset");
    // R4 version negotiation
    setreg(0, 32'h9000_0001); get(1, 32'h9000_0001, "R4 accept v1");
    put(1, 32'h9000_0003);    get(1, 32'h9000_0001, "R4 reject 3");
    put(1, 32'h1234_5678);    get(1, 32'h9000_0001, "R4 reject junk");
    put(1, 32'h9000_0000);    get(1, 32'h9000_0000, "R4 accept v0");
    // R5 bounds, R7 pitch
    setreg(2, 32'd1024); chk("R5 width 1024", 32'(width), 1024);
    rdreg(12, 32'd4096, "R7 pitch 1024");
    setreg(2, MAX_W);    chk("R5 width max", 32'(width), MAX_W);
    put(1, MAX_W + 1);   chk("R5 width over", 32'(width), MAX_W);
    rdreg(12, 32'd9472, "R7 pitch max");
    setreg(2, 32'd1);    rdreg(12, 32'd4, "R7 pitch 1");
    setreg(3, MAX_H);    chk("R5 height max", 32'(height), MAX_H);
    put(1, MAX_H + 1);   chk("R5 height over", 32'(height), MAX_H);
    get(1, MAX_H, "R5 height readback");
    // R6 depth
    rdreg(6, 32'd24, "R6 depth");
    rdreg(7, 32'd32, "R6 bpp");
    // R10 caps and limits
    rdreg(17, 32'h0000_00E3, "R10 caps");
    rdreg(4, MAX_W, "R10 max width");
    rdreg(5, MAX_H, "R10 max height");
    // R8 scratch window
    setreg(1792, 32'hA5A5_0001); chk("R8 no bad on scratch", {31'd0, bad_reg}, 0);
    setreg(1799, 32'h5A5A_0002);
    rdreg(1792, 32'hA5A5_0001, "R8 scratch first");
    rdreg(1799, 32'h5A5A_0002, "R8 scratch last");
    setreg(1800, 32'hDEAD_BEEF); chk("R8 bad on write past", {31'd0, bad_reg}, 1);
    @(negedge clk); chk("R8 bad pulse ends", {31'd0, bad_reg}, 0);
    rdreg(1800, 32'd0, "R8 read past zero"); chk("R8 bad on read past", {31'd0, bad_reg}, 1);
    rdreg(1791, 32'd0, "R8 read below zero"); chk("R8 bad below", {31'd0, bad_reg}, 1);
    // R9 cursor
    setreg(27, 32'd1); chk("R9 show 1", {31'd0, cursor_visible}, 1);
    put(1, 32'd2);     chk("R9 keep on 2", {31'd0, cursor_visible}, 1);
    put(1, 32'd0);     chk("R9 hide 0", {31'd0, cursor_visible}, 0);
    put(1, 32'd3);     chk("R9 keep off 3", {31'd0, cursor_visible}, 0);
    put(1, 32'd1);     get(1, 32'd1, "R9 show readback");
    setreg(25, 32'd100); chk("R9 cursor_x", cursor_x, 100);
    setreg(26, 32'd77);  chk("R9 cursor_y", cursor_y, 77);
    setreg(24, 32'd9);   chk("R9 cursor_id", cursor_id, 9);
    get(1, 32'd9, "R9 id readback");
    // R11 sync
    setreg(21, 32'd5); chk("R11 sync pulse", {31'd0, sync_start}, 1);
    @(negedge clk);    chk("R11 sync one cycle", {31'd0, sync_start}, 0);
    put(1, 32'd0);     chk("R11 zero no pulse", {31'd0, sync_start}, 0);
    // R13 enable / config
    setreg(1, 32'd7);  chk("R13 enable nz", {31'd0, enable}, 1);
    get(1, 32'd1, "R13 enable readback");
    put(1, 32'd0);     chk("R13 enable zero", {31'd0, enable}, 0);
    setreg(20, 32'h100); chk("R13 config", {31'd0, config_done}, 1);
    // R2 port map
    put(0, 32'd33);
    get(2, 32'd0, "R2 fw port reads 0");
    put(2, 32'd55);
    put(3, 32'd66);
    get(3, 32'hFFFF_FFFF, "R2 unmapped offset");
    get(0, 32'd33, "R2 index after ignored writes");
    // R3 access size
    put(0, 32'd44, 2);
    get(0, 32'd33, "R3 narrow write ignored");
    get(0, 32'hFFFF_FFFF, "R3 narrow read ones", 1);
    // R12 back-to-back reads
    @(negedge clk); addr = 4'd0; rd_en = 1'b1;
    exp_q.push_back(32'd33); tag_q.push_back("R12 back-to-back a");
    @(negedge clk);
    exp_q.push_back(32'd33); tag_q.push_back("R12 back-to-back b");
    @(negedge clk); rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 all reads returned", 32'(exp_q.size()), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule